// File: doc/BRIEF.md
# Ethernet Transmit Status Collector

This block sits beside the transmit engine of a half-duplex Ethernet MAC and condenses everything that happened to one outgoing frame into a single status byte for a host. The engine reports outcomes as one-cycle pulses: FIFO underflow, late collision, a retry attempt, a deferral, carrier loss and a retry-limit abort. It also marks the frame's boundaries with a start strobe and a done strobe. The block accumulates these events between the strobes and counts retries up to a saturation point. On the done strobe it latches the resulting byte, with its top bit set to show that the status is valid.

The host side is a valid/ready output stream. `sts_valid` mirrors bit 7 of `sts_data`. A transfer happens on a rising clock edge where `sts_valid` and `sts_ready` are both high, and on the following clock the valid bit is cleared while bits 6..0 hold. The transmit engine never waits for the host, so there is no back-pressure toward the MAC. If a newer frame completes before the host has read the byte, the newer status replaces the older one. `sts_ready` only decides when a pending status is consumed.

Top module: `tx_outcome_collector`

## Requirements
- R1: After reset `sts_data` is 8'h00 and `sts_valid` is low.
- R2: Bit 7 of `sts_data` (and `sts_valid`) rises only in the clock after a cycle with `frame_done` high. The full byte becomes visible in that same clock.
- R3: The latched byte shows underflow in bit 6, late collision in bit 5, carrier loss in bit 1 and retry-limit abort in bit 0. Each bit is set if and only if its pulse occurred from the `frame_start` cycle through the `frame_done` cycle, both inclusive.
- R4: Bit 2 is set if at least one deferral pulse occurred during the frame.
- R5: Bit 3 is set when exactly one retry pulse occurred, and bit 4 is set when two or more occurred. With none, both are clear. Bits 3 and 4 are never set together, however many retries occur.
- R6: `frame_start` discards all events seen before it, so pulses arriving between frames have no effect on the next latched byte.
- R7: A handshake (`sts_valid` and `sts_ready` high at a clock edge, with no `frame_done`) clears the valid bit on that edge. Bits 6..0 are left unchanged.
- R8: A `frame_done` while the previous status is still unread overwrites it, and only the newer byte is delivered.
- R9: When `frame_done` and a handshake fall on the same edge, the host receives the older byte and the newer byte is then presented with valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse: a new frame attempt begins |
| frame_done | input | 1 | Pulse: the frame's outcome is final |
| ev_underflow | input | 1 | Pulse: transmit FIFO ran dry |
| ev_late_col | input | 1 | Pulse: collision after the slot time |
| ev_retry | input | 1 | Pulse: one retry attempt was made |
| ev_defer | input | 1 | Pulse: transmission had to defer |
| ev_carrier_loss | input | 1 | Pulse: carrier dropped during transmit |
| ev_abort | input | 1 | Pulse: frame given up at the retry limit |
| sts_valid | output | 1 | Status byte holds an unread outcome |
| sts_ready | input | 1 | Host accepts the status byte |
| sts_data | output | 8 | Status byte; bit 7 is the valid flag |

## Verification
The bench builds the block with its default retry saturation of 2. This brings the saturating edge within a handful of pulses: frames with zero, one, exactly two and five retries exercise every path of the one-versus-many encoding, and show that the counter holding at its limit never sets both flags. The bench also drives overwrite-before-read, a read on the same edge as a done strobe, and stray pulses between frames.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STS_W       = 8;
  localparam int BIT_VALID   = 7;
  localparam int BIT_UNDER   = 6;
  localparam int BIT_LATECOL = 5;
  localparam int BIT_MANY    = 4;
  localparam int BIT_ONE     = 3;
  localparam int BIT_DEFER   = 2;
  localparam int BIT_NOCARR  = 1;
  localparam int BIT_ABORT   = 0;

  localparam int NUM_FLAGS   = 5;

  typedef struct packed {
    logic underflow;
    logic late_col;
    logic defer;
    logic carrier_loss;
    logic abort;
  } txs_flags_t;

  function automatic logic [STS_W-2:0] txs_pack(input txs_flags_t f,
                                                 input logic one_retry,
                                                 input logic many_retry);
    logic [STS_W-1:0] b;
    b              = '0;
    b[BIT_UNDER]   = f.underflow;
    b[BIT_LATECOL] = f.late_col;
    b[BIT_MANY]    = many_retry;
    b[BIT_ONE]     = one_retry;
    b[BIT_DEFER]   = f.defer;
    b[BIT_NOCARR]  = f.carrier_loss;
    b[BIT_ABORT]   = f.abort;
    return b[STS_W-2:0];
  endfunction
endpackage

// File: rtl/txs_event_accum.sv
module txs_event_accum #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] ev,
  output logic [N-1:0] live
);
  logic [N-1:0] acc_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // The start cycle's own pulses belong to the new frame.
    assign live[i] = start ? ev[i] : (acc_q[i] | ev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[i] <= 1'b0;
      else        acc_q[i] <= live[i];
    end
  end
endmodule

// File: rtl/txs_retry_track.sv
module txs_retry_track #(
  parameter int RETRY_SAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic retry,
  output logic one_retry,
  output logic many_retry
);
  localparam int CNT_W = $clog2(RETRY_SAT + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(RETRY_SAT);

  logic [CNT_W-1:0] cnt_q, base, cnt_live;

  always_comb begin
    base     = start ? '0 : cnt_q;
    cnt_live = (retry && base < SAT) ? base + 1'b1 : base;
  end

  assign one_retry  = (cnt_live == CNT_W'(1));
  assign many_retry = (cnt_live >= CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_live;
  end
endmodule

// File: rtl/txs_status_reg.sv
module txs_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-2:0] cap_bits,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic         valid_q;
  logic [W-2:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      bits_q  <= cap_bits;
    end else if (valid_q && rd_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = {valid_q, bits_q};
endmodule

// File: rtl/tx_outcome_collector.sv
module tx_outcome_collector
  import txs_pkg::*;
#(
  parameter int RETRY_SAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic             ev_underflow,
  input  logic             ev_late_col,
  input  logic             ev_retry,
  input  logic             ev_defer,
  input  logic             ev_carrier_loss,
  input  logic             ev_abort,
  output logic             sts_valid,
  input  logic             sts_ready,
  output logic [STS_W-1:0] sts_data
);
  txs_flags_t ev_vec, live_flags;
  logic       one_r, many_r;

  assign ev_vec = '{underflow:    ev_underflow,
                    late_col:     ev_late_col,
                    defer:        ev_defer,
                    carrier_loss: ev_carrier_loss,
                    abort:        ev_abort};

  txs_event_accum #(.N(NUM_FLAGS)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .start (frame_start),
    .ev    (ev_vec),
    .live  (live_flags)
  );

  txs_retry_track #(.RETRY_SAT(RETRY_SAT)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .retry      (ev_retry),
    .one_retry  (one_r),
    .many_retry (many_r)
  );

  txs_status_reg #(.W(STS_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (frame_done),
    .cap_bits (txs_pack(live_flags, one_r, many_r)),
    .rd_ready (sts_ready),
    .rd_valid (sts_valid),
    .rd_data  (sts_data)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_done,
  input logic       ev_underflow,
  input logic       sts_valid,
  input logic       sts_ready,
  input logic [7:0] sts_data
);
  assert_valid_needs_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_valid) |-> $past(frame_done));

  assert_done_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (sts_valid && sts_data[7]));

  assert_underflow_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ev_underflow) |=> sts_data[6]);

  assert_retry_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_data[4] && sts_data[3]));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_ready && !frame_done) |=> !sts_valid);

  assert_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(sts_data[6:0]));
endmodule

bind tx_outcome_collector txs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_done   (frame_done),
  .ev_underflow (ev_underflow),
  .sts_valid    (sts_valid),
  .sts_ready    (sts_ready),
  .sts_data     (sts_data)
);

// File: tb/tb_tx_outcome_collector.sv
module tb_tx_outcome_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, frame_done = 0;
  logic ev_underflow = 0, ev_late_col = 0, ev_retry = 0;
  logic ev_defer = 0, ev_carrier_loss = 0, ev_abort = 0;
  logic sts_ready = 0;
  logic sts_valid;
  logic [7:0] sts_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string mon_tag = "R3";

  always #5 clk = ~clk;

  tx_outcome_collector dut (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_done(frame_done),
    .ev_underflow(ev_underflow), .ev_late_col(ev_late_col),
    .ev_retry(ev_retry), .ev_defer(ev_defer),
    .ev_carrier_loss(ev_carrier_loss), .ev_abort(ev_abort),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_data(sts_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every handshake.
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && sts_valid && sts_ready) begin
      if (exp_q.size() == 0) chk(0, mon_tag, sts_data, 8'hxx);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(sts_data == e, mon_tag, sts_data, e);
      end
    end
  end

  // Driver: one frame, pushes expected byte after the done edge.
  task automatic run_frame(input bit uf, input bit lc, input int retries,
                           input bit df, input bit cl, input bit ab,
                           input bit rd_same);
    logic [7:0] e;
    e = 8'h80 | {1'b0, uf, lc, (retries >= 2), (retries == 1), df, cl, ab};
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    if (uf) begin ev_underflow = 1; @(negedge clk); ev_underflow = 0; end
    if (lc) begin ev_late_col = 1; @(negedge clk); ev_late_col = 0; end
    if (df) begin ev_defer = 1; @(negedge clk); ev_defer = 0; end
    if (cl) begin ev_carrier_loss = 1; @(negedge clk); ev_carrier_loss = 0; end
    for (int i = 0; i < retries; i++) begin
      ev_retry = 1; @(negedge clk); ev_retry = 0; @(negedge clk);
    end
    if (ab) begin ev_abort = 1; @(negedge clk); ev_abort = 0; end
    frame_done = 1;
    if (rd_same) sts_ready = 1;
    @(posedge clk); #1;
    frame_done = 0;
    sts_ready = 0;
    if (exp_q.size() > 0) void'(exp_q.pop_front()); // R8: unread byte overwritten
    exp_q.push_back(e);
    chk(sts_valid && sts_data == e, "R2", sts_data, e);
  endtask

  task automatic host_read();
    @(negedge clk); sts_ready = 1;
    @(negedge clk); sts_ready = 0;
    #2 chk(!sts_valid, "R7", {7'd0, sts_valid}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sts_data == 8'h00 && !sts_valid, "R1", sts_data, 8'h00);
    rst_n = 1;

    mon_tag = "R2"; run_frame(0, 0, 0, 0, 0, 0, 0); host_read();
    mon_tag = "R3"; run_frame(1, 0, 0, 0, 1, 0, 0); host_read();
    @(negedge clk);
    chk(sts_data == 8'h42, "R7", sts_data, 8'h42);
    mon_tag = "R3"; run_frame(0, 1, 3, 0, 0, 1, 0); host_read();
    mon_tag = "R4"; run_frame(0, 0, 1, 1, 0, 0, 0); host_read();
    mon_tag = "R5"; run_frame(0, 0, 2, 0, 0, 0, 0); host_read();
    mon_tag = "R5"; run_frame(0, 0, 5, 0, 0, 0, 0); host_read();
    mon_tag = "R5"; run_frame(0, 0, 1, 0, 0, 0, 0); host_read();

    // R6: stray pulses between frames must vanish at frame_start
    @(negedge clk); ev_underflow = 1; ev_retry = 1; ev_abort = 1;
    @(negedge clk); ev_underflow = 0; ev_retry = 0; ev_abort = 0;
    mon_tag = "R6"; run_frame(0, 0, 0, 0, 0, 0, 0); host_read();

    // R8: unread status overwritten by newer frame
    mon_tag = "R8";
    run_frame(1, 0, 0, 0, 0, 0, 0);
    run_frame(0, 0, 0, 1, 0, 0, 0);
    host_read();

    // R9: done and read on the same edge
    mon_tag = "R9";
    run_frame(0, 0, 0, 0, 1, 0, 0);
    run_frame(0, 1, 0, 0, 0, 0, 1);
    @(negedge clk);
    chk(sts_valid && sts_data == 8'hA0, "R9", sts_data, 8'hA0);
    host_read();

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule